// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block lets a clocked system read and write an external asynchronous static RAM of 64K words by 16 bits. The host issues one request at a time over a valid/ready handshake. Each request carries a word address, write data, a two-bit byte mask and a write flag. A read returns its data on `rsp_data` together with a one-cycle `rsp_valid` pulse. On the memory side the block drives the address and five active-low strobes: chip select, output enable, write strobe, and one strobe for each byte lane. It also owns a shared bidirectional 16-bit data bus, which it drives only during writes.

The memory has no clock, so every strobe width is counted in clock cycles. The counts come from parameters that give the clock period and the minimum nanosecond values. Each count is the division rounded up, so the nanosecond minimum is always met. Output enable stays high for the whole of a write, so the shorter write-pulse minimum applies. The byte mask drives the two lane strobes on reads as well as writes. When a write follows a read, the block inserts configurable idle cycles so that the memory has released the bus before the controller drives it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and the chip select, output enable, write strobe and both lane strobes are all 1 (inactive).
- R2: A write with `req_be`=2'b11 stores `req_wdata` at `req_addr`. A later read of that address with `req_be`=2'b11 returns the same word.
- R3: `req_be[0]` selects the low byte, which is data bits 7:0 and strobe `ram_lo_n`. `req_be[1]` selects the high byte, which is bits 15:8 and strobe `ram_hi_n`. A write changes only the selected bytes, and a write with mask 2'b00 changes nothing.
- R4: Output enable is high in every cycle in which the write strobe is low. The controller starts driving the data bus only after a cycle in which output enable was high.
- R5: A read holds chip select, output enable and the selected lane strobes low for RD_CYC = ceil(RD_NS/CLK_NS) cycles (3 by default). The data is captured on the edge that ends that count, so `rsp_valid` goes high RD_CYC edges after the accepting edge.
- R6: `rsp_valid` is high for exactly one cycle per read, and a byte lane whose mask bit is 0 reads back as zero.
- R7: The write strobe stays low for W_LOW cycles, where W_LOW is the largest of ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS) and ceil(WC_NS/CLK_NS)-1 (2 by default). One hold cycle follows, with chip select still low and the data still driven.
- R8: A write whose previous completed operation was a read is preceded by TURN_CYC idle cycles (1 by default). Any other write starts its strobe on the edge after the accepting edge.
- R9: While chip select stays low, the address and the lane strobes do not change.
- R10: `req_ready` is high only while no access is in progress, and chip select is high whenever `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, accepts request |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_data | output | 16 | Read data, unselected bytes zero |
| rsp_valid | output | 1 | One-cycle read data strobe |
| ram_a | output | 16 | Memory address |
| ram_sel_n | output | 1 | Chip select, active low |
| ram_rden_n | output | 1 | Output enable, active low |
| ram_wstb_n | output | 1 | Write strobe, active low |
| ram_lo_n | output | 1 | Low-byte lane strobe, active low |
| ram_hi_n | output | 1 | High-byte lane strobe, active low |
| ram_dq | inout | 16 | Shared data bus |

## Verification
The assertions check four things on every cycle: write strobe and output enable are never low together, the bus is never driven straight out of a read, the response pulse lasts one cycle, and address and lanes hold while chip select is low. They also count the write-strobe width against its minimum and check that ready implies the chip is deselected. The bench scenarios use a behavioural memory that honours the lane strobes, which is the only way to show the rest. Those scenarios cover masked writes that leave the other byte untouched, zeroed lanes on masked reads, the exact read latency, and the extra turnaround cycle when a write follows a read.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CLK_NS   = 4,
  parameter int RD_NS    = 10,
  parameter int WP_NS    = 7,
  parameter int DS_NS    = 5,
  parameter int WC_NS    = 10,
  parameter int TURN_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  input  logic          req_write,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_valid,
  output logic [AW-1:0] ram_a,
  output logic          ram_sel_n,
  output logic          ram_rden_n,
  output logic          ram_wstb_n,
  output logic          ram_lo_n,
  output logic          ram_hi_n,
  inout  wire  [DW-1:0] ram_dq
);
  localparam int LW     = DW / 2;
  localparam int CW     = 8;
  localparam int RD_RAW = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WP_CYC = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DS_CYC = (DS_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_CYC = (WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int W_A    = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;
  localparam int W_B    = (W_A > WC_CYC - 1) ? W_A : WC_CYC - 1;
  localparam int W_LOW  = (W_B < 1) ? 1 : W_B;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_WH} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic [1:0]    m_q;
  logic          last_rd;

  wire act = (st == S_RD) || (st == S_WR) || (st == S_WH);
  wire drv = (st == S_WR) || (st == S_WH);

  assign req_ready  = (st == S_IDLE);
  assign ram_a      = a_q;
  assign ram_sel_n  = !act;
  assign ram_rden_n = (st != S_RD);
  assign ram_wstb_n = (st != S_WR);
  assign ram_lo_n   = !(act && m_q[0]);
  assign ram_hi_n   = !(act && m_q[1]);
  assign ram_dq     = drv ? wd_q : 'z;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      a_q       <= '0;
      wd_q      <= '0;
      m_q       <= '0;
      last_rd   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          wd_q <= req_wdata;
          m_q  <= req_be;
          if (!req_write) begin
            st  <= S_RD;
            cnt <= CW'(RD_CYC - 1);
          end else if (last_rd && TURN_CYC > 0) begin
            st  <= S_TURN;
            cnt <= CW'(TURN_CYC - 1);
          end else begin
            st  <= S_WR;
            cnt <= CW'(W_LOW - 1);
          end
        end
        S_RD: if (cnt == '0) begin
          rsp_data  <= ram_dq & {{LW{m_q[1]}}, {LW{m_q[0]}}};
          rsp_valid <= 1'b1;
          last_rd   <= 1'b1;
          st        <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) begin
          st  <= S_WR;
          cnt <= CW'(W_LOW - 1);
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) st <= S_WH;
              else cnt <= cnt - 1'b1;
        S_WH: begin
          st      <= S_IDLE;
          last_rd <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] wlo_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wlo_cnt <= '0;
    else if (!ram_wstb_n) wlo_cnt <= wlo_cnt + 1'b1;
    else                  wlo_cnt <= '0;
  end

  assert_wstb_rden_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_wstb_n |-> ram_rden_n);
  assert_drive_after_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drv && !$past(drv)) |-> ($past(ram_rden_n) && ram_rden_n));
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n && !$past(ram_sel_n)) |-> ($stable(ram_a) && $stable(ram_lo_n) && $stable(ram_hi_n)));
  assert_wstb_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_wstb_n) |-> (wlo_cnt >= CW'(W_LOW)));
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ram_sel_n);
endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
  localparam int EXP_RD = 3;
  localparam int EXP_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_write = 1'b0;
  logic [15:0] rsp_data;
  logic        rsp_valid;
  logic [15:0] ram_a;
  logic ram_sel_n, ram_rden_n, ram_wstb_n, ram_lo_n, ram_hi_n;
  wire  [15:0] ram_dq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .ram_a(ram_a), .ram_sel_n(ram_sel_n),
    .ram_rden_n(ram_rden_n), .ram_wstb_n(ram_wstb_n), .ram_lo_n(ram_lo_n),
    .ram_hi_n(ram_hi_n), .ram_dq(ram_dq));

  // behavioural memory, 1024 words indexed by the low address bits
  logic [15:0] mem [0:1023];
  wire mdrv = !ram_sel_n && !ram_rden_n && ram_wstb_n;
  assign ram_dq[7:0]  = (mdrv && !ram_lo_n) ? mem[ram_a[9:0]][7:0]  : 8'hzz;
  assign ram_dq[15:8] = (mdrv && !ram_hi_n) ? mem[ram_a[9:0]][15:8] : 8'hzz;
  always @(posedge ram_wstb_n) begin
    if (ram_sel_n === 1'b0) begin
      if (!ram_lo_n) mem[ram_a[9:0]][7:0]  <= ram_dq[7:0];
      if (!ram_hi_n) mem[ram_a[9:0]][15:8] <= ram_dq[15:8];
    end
  end

  int cur_w = 0, last_w = 0, bad_oe = 0, bad_addr = 0;
  logic prev_sel_n = 1'b1;
  logic [15:0] prev_a = '0;
  always @(negedge clk) begin
    if (!ram_wstb_n) cur_w++;
    else if (cur_w != 0) begin last_w = cur_w; cur_w = 0; end
    if (!ram_wstb_n && !ram_rden_n) bad_oe++;
    if (!ram_sel_n && !prev_sel_n && ram_a != prev_a) bad_addr++;
    prev_sel_n = ram_sel_n;
    prev_a = ram_a;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be, input logic wr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_wdata = d; req_be = be; req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be,
                          input bit exp_turn, input string req);
    issue(a, d, be, 1'b1);
    if (exp_turn) begin
      chk(ram_wstb_n == 1'b1, req, ram_wstb_n, 1);
      @(negedge clk);
    end
    chk(ram_wstb_n == 1'b0, req, ram_wstb_n, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] be, input logic [15:0] exp,
                         input string req);
    int k;
    issue(a, 16'h0, be, 1'b0);
    k = 0;
    while (!rsp_valid && k < 20) begin @(negedge clk); k++; end
    chk(k == EXP_RD, "R5 latency", k, EXP_RD);
    chk(rsp_data == exp, req, rsp_data, exp);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R6 pulse", rsp_valid, 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 handshake", {req_ready, rsp_valid}, 2'b10);
    chk({ram_sel_n, ram_rden_n, ram_wstb_n, ram_lo_n, ram_hi_n} == 5'b11111, "R1 strobes",
        {ram_sel_n, ram_rden_n, ram_wstb_n, ram_lo_n, ram_hi_n}, 5'b11111);
    chk(ram_sel_n == 1'b1, "R10 idle deselect", ram_sel_n, 1);
  endtask

  task automatic t_full_word;
    do_write(16'h0000, 16'hA5C3, 2'b11, 0, "R8 no turn after reset");
    do_write(16'hFFFF, 16'h1E2F, 2'b11, 0, "R8 no turn after write");
    do_read(16'h0000, 2'b11, 16'hA5C3, "R2 readback low address");
    do_read(16'hFFFF, 2'b11, 16'h1E2F, "R2 readback high address");
    do_write(16'h4321, 16'h7788, 2'b11, 1, "R8 turn after read");
    do_read(16'h4321, 2'b11, 16'h7788, "R2 readback after turn");
  endtask

  task automatic t_masked;
    do_write(16'h1234, 16'h1111, 2'b11, 1, "R8 turn after read");
    do_write(16'h1234, 16'hAAAA, 2'b01, 0, "R3 low strobe");
    do_read(16'h1234, 2'b11, 16'h11AA, "R3 low byte only");
    do_write(16'h1234, 16'hBBBB, 2'b10, 1, "R3 high strobe");
    do_read(16'h1234, 2'b11, 16'hBBAA, "R3 high byte only");
    do_write(16'h1234, 16'hCCCC, 2'b00, 1, "R3 no-lane strobe");
    do_read(16'h1234, 2'b11, 16'hBBAA, "R3 empty mask no change");
  endtask

  task automatic t_lane_read;
    do_read(16'h1234, 2'b01, 16'h00AA, "R6 high lane zero");
    do_read(16'h1234, 2'b10, 16'hBB00, "R6 low lane zero");
    do_read(16'h1234, 2'b00, 16'h0000, "R6 both lanes zero");
  endtask

  task automatic t_timing;
    chk(last_w == EXP_W, "R7 write strobe width", last_w, EXP_W);
    chk(bad_oe == 0, "R4 oe high in write", bad_oe, 0);
    chk(bad_addr == 0, "R9 address hold", bad_addr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full_word;
    t_masked;
    t_lane_read;
    repeat (4) @(negedge clk);
    t_timing;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule